// File: doc/BRIEF.md
# Serial Mixer Gain Control Port

This block receives 8-bit command bytes over a three-signal serial interface and maintains a bank of gain registers for a mixer. The interface has a serial clock, a serial data line and an active-low write strobe. All three are treated as signals that are already synchronous to the system clock `clk`. Data is taken on each low-to-high transition of the serial clock while the strobe is held low. The serial clock may rest either high or low between bits.

Each byte is sorted by its most significant bit. An address byte (bit 7 = 1) picks a gain channel. A data byte (bit 7 = 0) carries a 7-bit gain code for the channel picked last. Codes land in holding registers first. The active gain outputs take the whole bank at once on a load event. A load event comes either from a separate active-low load input or, in three-wire mode, from the end of the write strobe itself. The serial output presents the top bit of the internal shift register, so several ports can be chained on one strobe.

Top module: `serial_gain_port`

## Requirements
- R1: After reset every active gain output is 0, `sdo` is 0 and `orphan` is 0.
- R2: While `wr_n` is low, each 0-to-1 transition of `sclk` shifts `sdi` in, most significant bit first. Every eighth such transition completes one byte.
- R3: A byte with bit 7 = 1 is an address byte, and bits 3:0 give the channel index. An index of `NUM_CH` or more is ignored, and the previous selection stays in force.
- R4: A byte with bit 7 = 0 is a data byte. Its bits 6:0 are written to the holding register of the selected channel. Consecutive data bytes all go to that same channel, the last one wins, and other channels are untouched.
- R5: A data byte that arrives in a write sequence before any accepted address byte is dropped and sets `orphan`. Once set, `orphan` stays 1 until reset. The address selection becomes invalid at the end of every write sequence.
- R6: If `wr_n` returns high partway through a byte, the partial bits are never decoded. The next sequence starts framing afresh at its first bit.
- R7: Active gain outputs change only in the cycle after a load event. When a load event occurs, all channels copy their holding registers together.
- R8: With `three_wire` = 1, the rise of `wr_n` is itself a load event, and `ld_n` has no effect.
- R9: With `three_wire` = 0, a falling edge of `ld_n` seen while `wr_n` is high is a load event. A falling edge of `ld_n` while `wr_n` is low is ignored, and the rise of `wr_n` does not load.
- R10: `sdo` equals bit 7 of the shift register. It changes only in the cycle after a shifting `sclk` rise, so a byte leaves on `sdo`, MSB first, during the following byte.
- R11: Bytes are framed identically whether `sclk` rests high or low while the strobe is asserted and released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, data taken on its rise |
| sdi | input | 1 | Serial data in |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Separate load strobe, active low (four-wire mode) |
| three_wire | input | 1 | 1 = load generated at end of write strobe |
| sdo | output | 1 | Serial data out for chaining |
| gain_out | output | NUM_CH*7 | Active gain codes, channel c at bits [c*7 +: 7] |
| orphan | output | 1 | Sticky flag: data byte arrived without an address |

## Verification
The bench aims at several corner cases, and each one shows a distinct failure in a broken design:
- **Out-of-range index:** a design that accepts it would write a ghost channel or move the selection.
- **Strobe released mid-byte:** a design that keeps the partial count would decode misaligned bytes in the next sequence.
- **Data before an address:** a design that lets it through would write channel 0 or a stale channel.
- **Load asserted during a write:** a design that honours it would update the outputs early.
- **Both clock idle levels:** a design that frames on the wrong edge would get shifted bytes.

Constrained random sequences in both modes are compared against a bench model of the holding and active banks, and `sdo` is checked after every bit.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int CODE_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_ADDR = 1'b1
    } byte_kind_e;

    typedef struct packed {
        logic              valid;
        byte_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
    } cmd_t;

    function automatic cmd_t decode_byte(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.valid = 1'b0;
        c.kind  = byte_kind_e'(b[BYTE_W-1]);
        c.addr  = b[ADDR_W-1:0];
        c.code  = b[CODE_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/sgp_edges.sv
module sgp_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic wr_n,
    input  logic ld_n,
    input  logic three_wire,
    output logic sclk_rise,
    output logic wr_active,
    output logic wr_end,
    output logic load_pulse
);
    logic sclk_q;
    logic wr_q;
    logic ld_q;
    logic ld_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            wr_q   <= 1'b1;
            ld_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            wr_q   <= wr_n;
            ld_q   <= ld_n;
        end
    end

    always_comb begin
        sclk_rise = sclk & ~sclk_q;
        wr_active = ~wr_n;
        wr_end    = wr_n & ~wr_q;
        ld_fall   = ~ld_n & ld_q;
        if (three_wire) begin
            load_pulse = wr_end;
        end else begin
            load_pulse = ld_fall & wr_n;
        end
    end
endmodule

// File: rtl/sgp_framer.sv
module sgp_framer
    import sgp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_rise,
    input  logic wr_active,
    input  logic wr_end,
    input  logic sdi,
    output cmd_t cmd,
    output logic sdo
);
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] next_byte;
    logic              take_bit;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    always_comb begin
        take_bit  = sclk_rise & wr_active;
        next_byte = {shreg[BYTE_W-2:0], sdi};
        cmd       = decode_byte(next_byte);
        cmd.valid = take_bit && (bit_cnt == LAST_BIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (wr_end) begin
            bit_cnt <= '0;
        end else if (take_bit) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign sdo = shreg[BYTE_W-1];
endmodule

// File: rtl/sgp_gain_bank.sv
module sgp_gain_bank
    import sgp_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cmd_t                     cmd,
    input  logic                     wr_end,
    input  logic                     load_pulse,
    output logic [NUM_CH*CODE_W-1:0] gain_out,
    output logic                     orphan
);
    logic [ADDR_W-1:0] sel;
    logic              sel_valid;
    logic              addr_ok;
    logic              data_hit;

    always_comb begin
        addr_ok  = cmd.valid && (cmd.kind == KIND_ADDR) && (int'(cmd.addr) < NUM_CH);
        data_hit = cmd.valid && (cmd.kind == KIND_DATA) && sel_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel       <= '0;
            sel_valid <= 1'b0;
            orphan    <= 1'b0;
        end else begin
            if (wr_end) begin
                sel_valid <= 1'b0;
            end else if (addr_ok) begin
                sel       <= cmd.addr;
                sel_valid <= 1'b1;
            end
            if (cmd.valid && (cmd.kind == KIND_DATA) && !sel_valid) begin
                orphan <= 1'b1;
            end
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] hold_q;
        logic [CODE_W-1:0] act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
                act_q  <= '0;
            end else begin
                if (data_hit && (int'(sel) == ch)) begin
                    hold_q <= cmd.code;
                end
                if (load_pulse) begin
                    act_q <= hold_q;
                end
            end
        end
        assign gain_out[ch*CODE_W +: CODE_W] = act_q;
    end
endmodule

// File: rtl/serial_gain_port.sv
module serial_gain_port
    import sgp_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     wr_n,
    input  logic                     ld_n,
    input  logic                     three_wire,
    output logic                     sdo,
    output logic [NUM_CH*CODE_W-1:0] gain_out,
    output logic                     orphan
);
    logic sclk_rise;
    logic wr_active;
    logic wr_end;
    logic load_pulse;
    cmd_t cmd;

    sgp_edges u_edges (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .wr_n       (wr_n),
        .ld_n       (ld_n),
        .three_wire (three_wire),
        .sclk_rise  (sclk_rise),
        .wr_active  (wr_active),
        .wr_end     (wr_end),
        .load_pulse (load_pulse)
    );

    sgp_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .wr_active (wr_active),
        .wr_end    (wr_end),
        .sdi       (sdi),
        .cmd       (cmd),
        .sdo       (sdo)
    );

    sgp_gain_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .wr_end     (wr_end),
        .load_pulse (load_pulse),
        .gain_out   (gain_out),
        .orphan     (orphan)
    );
endmodule

// File: rtl/sgp_checker.sv
module sgp_checker #(
    parameter int GW = 56
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_n,
    input logic          three_wire,
    input logic          sclk_rise,
    input logic          load_pulse,
    input logic          sdo,
    input logic          orphan,
    input logic [GW-1:0] gain_out
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (gain_out == '0 && !sdo && !orphan)); // R1

    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_pulse |=> $stable(gain_out)); // R7

    AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (rst)
        orphan |=> orphan); // R5

    AST_THREE_WIRE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (three_wire && $rose(wr_n)) |-> load_pulse); // R8

    AST_LOAD_OUTSIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> wr_n); // R9

    AST_SDO_STEADY: assert property (@(posedge clk) disable iff (rst)
        !sclk_rise |=> $stable(sdo)); // R10
endmodule

bind serial_gain_port sgp_checker #(.GW(NUM_CH*sgp_pkg::CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_n       (wr_n),
    .three_wire (three_wire),
    .sclk_rise  (sclk_rise),
    .load_pulse (load_pulse),
    .sdo        (sdo),
    .orphan     (orphan),
    .gain_out   (gain_out)
);

// File: tb/sim_serial_gain_port.sv
module sim_serial_gain_port;
    localparam int CLK_P  = 10;
    localparam int NCH    = 8;
    localparam int CW     = 7;

    logic clk = 0;
    logic rst = 1;
    logic sclk = 0, sdi = 0, wr_n = 1, ld_n = 1, three_wire = 1;
    logic sdo, orphan;
    logic [NCH*CW-1:0] gain_out;

    serial_gain_port #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .wr_n(wr_n),
        .ld_n(ld_n), .three_wire(three_wire), .sdo(sdo),
        .gain_out(gain_out), .orphan(orphan)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic idle_hi = 0;

    logic [CW-1:0] m_hold [NCH];
    logic [CW-1:0] m_act  [NCH];
    logic [3:0]    m_sel;
    logic          m_valid;
    logic          m_orph;
    logic [7:0]    m_sh;
    int            m_cnt;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic void model_byte(input logic [7:0] b);
        if (b[7]) begin
            if (int'(b[3:0]) < NCH) begin
                m_sel   = b[3:0];
                m_valid = 1'b1;
            end
        end else if (m_valid) begin
            m_hold[m_sel] = b[6:0];
        end else begin
            m_orph = 1'b1;
        end
    endfunction

    function automatic void model_load();
        for (int c = 0; c < NCH; c++) m_act[c] = m_hold[c];
    endfunction

    task automatic send_bit(input logic b);
        sdi  = b;
        sclk = 1'b0;
        wait_n(2);
        sclk = 1'b1;
        wait_n(2);
        m_sh = {m_sh[6:0], b};
        m_cnt++;
        if (m_cnt == 8) begin
            model_byte(m_sh);
            m_cnt = 0;
        end
        check("R10 sdo", {31'd0, sdo}, {31'd0, m_sh[7]});
        if (!idle_hi) begin
            sclk = 1'b0;
            wait_n(2);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
    endtask

    task automatic begin_write();
        sclk = idle_hi;
        wait_n(2);
        wr_n = 1'b0;
        wait_n(2);
    endtask

    task automatic end_write();
        wr_n = 1'b1;
        wait_n(2);
        m_cnt   = 0;
        m_valid = 1'b0;
        if (three_wire) model_load();
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        wait_n(2);
        if (!three_wire && wr_n) model_load();
        ld_n = 1'b1;
        wait_n(2);
    endtask

    task automatic check_gains(input string req);
        for (int c = 0; c < NCH; c++)
            check(req, {25'd0, gain_out[c*CW +: CW]}, {25'd0, m_act[c]});
        check(req, {31'd0, orphan}, {31'd0, m_orph});
    endtask

    initial begin
        #(CLK_P * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int c = 0; c < NCH; c++) begin
            m_hold[c] = '0;
            m_act[c]  = '0;
        end
        m_sel = 0; m_valid = 0; m_orph = 0; m_sh = 0; m_cnt = 0;
        wait_n(3);
        rst = 0;
        wait_n(1);
        check("R1 sdo", {31'd0, sdo}, 32'd0);
        check_gains("R1 reset");

        // R2 R4 R8: address then two data bytes, three-wire auto load
        three_wire = 1;
        begin_write();
        send_bits(8'h83, 8);
        send_bits(8'h15, 8);
        send_bits(8'h6A, 8);
        check("R7 no load yet", {25'd0, gain_out[3*CW +: CW]}, 32'd0);
        end_write();
        check_gains("R4 R8 last data wins");

        // R3: out-of-range index keeps previous selection
        begin_write();
        send_bits(8'h82, 8);
        send_bits(8'h8C, 8);
        send_bits(8'h33, 8);
        end_write();
        check_gains("R3 index ignored");

        // R5: data with no address
        begin_write();
        send_bits(8'h44, 8);
        end_write();
        check_gains("R5 orphan");

        // R6: partial byte then fresh sequence
        begin_write();
        send_bits(8'h81, 5);
        end_write();
        begin_write();
        send_bits(8'h81, 8);
        send_bits(8'h5E, 8);
        end_write();
        check_gains("R6 partial dropped");

        // R9: four-wire, strobe end does not load, load during write ignored
        three_wire = 0;
        begin_write();
        send_bits(8'h80, 8);
        send_bits(8'h7F, 8);
        pulse_load();
        check_gains("R9 load in write ignored");
        end_write();
        check_gains("R9 no load at strobe end");
        pulse_load();
        check_gains("R9 load applied");

        // R8: three-wire ignores ld_n
        three_wire = 1;
        begin_write();
        send_bits(8'h85, 8);
        send_bits(8'h11, 8);
        pulse_load();
        check_gains("R8 ld_n ignored");
        end_write();
        check_gains("R8 auto load");

        // R11: idle-high clock
        idle_hi = 1;
        begin_write();
        send_bits(8'h87, 8);
        send_bits(8'h29, 8);
        end_write();
        check_gains("R11 idle high");

        // random sequences
        for (int s = 0; s < 40; s++) begin
            int nb;
            idle_hi    = $urandom_range(0, 1);
            three_wire = $urandom_range(0, 1);
            nb = $urandom_range(1, 4);
            begin_write();
            for (int k = 0; k < nb; k++) begin
                logic [7:0] b;
                b = $urandom_range(0, 255);
                if ($urandom_range(0, 9) < 4) b[7] = 1'b1;
                if ($urandom_range(0, 19) == 0)
                    send_bits(b, $urandom_range(1, 7));
                else
                    send_bits(b, 8);
            end
            end_write();
            if (!three_wire) pulse_load();
            check_gains("R2 R4 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule